// File: doc/BRIEF.md
# Power-Down and Wake Sequencer

This block puts a small system into a power-down state when the processor asks for it, and brings the system back out when a wake event arrives. A single command drops the power-supply enable, the clock output enable and the processor reset together. The same command also disables the serial interface for the whole of the power-down period.

Two kinds of event end power-down. The first is any enabled interrupt from the alarm, the periodic tick or the power-sense logic. The second is a supply recovery whose form depends on the supply mode. In battery-backup mode, the system supply must first fall to the battery level and then rise clear of it again. In single-supply mode, the supply level pin must go low and then return high. In both modes only a fall seen during power-down counts.

On wake, supply and clock come back at once. The processor reset and the serial-interface disable are then held for a programmable number of cycles before they release together. All inputs are plain synchronous control levels, and no data stream passes through the block.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, pse, clk_out_en and cpu_rst_n are 1, ser_dis is 0 and pd_cmd is 0.
- R2: A one-cycle pd_cmd_set pulse while running sets pd_cmd on the next clock edge. On the edge after that, pse, clk_out_en and cpu_rst_n all go to 0 and ser_dis goes to 1.
- R3: While powered down, the four outputs keep their power-down values until a wake event is sampled.
- R4: Interrupt bit 0 is the alarm, bit 1 is the periodic tick and bit 2 is power sense. A source wakes the block only when its irq_en bit is 1. A disabled source, or any interrupt while running, has no effect on the outputs.
- R5: With batt_mode=1, the block wakes on the first edge at which sys_above_batt is 1, provided sys_at_batt was sampled 1 on an earlier edge during the same power-down.
- R6: With batt_mode=0, the block wakes on the first edge at which sys_level is 1, provided sys_level was sampled 0 on an earlier edge during the same power-down.
- R7: A supply recovery without a fall during the current power-down never wakes the block. A fall that happened while running does not count. The supply inputs of the mode that is not selected are ignored.
- R8: On the edge that takes a wake, pse and clk_out_en return to 1. After that edge, cpu_rst_n stays 0 and ser_dis stays 1 for max(rst_hold_cycles,1) cycles, and then both release on the same edge.
- R9: pd_cmd clears on the edge that takes the wake, so one command gives exactly one power-down. A pd_cmd_set pulse while powered down or holding reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_cmd_set | input | 1 | Processor write of the power-down command bit |
| irq | input | 3 | Interrupt sources: alarm, periodic tick, power sense |
| irq_en | input | 3 | Per-source wake enable |
| batt_mode | input | 1 | 1 = battery-backup mode, 0 = single-supply mode |
| sys_at_batt | input | 1 | Supply has fallen to battery level (battery mode) |
| sys_above_batt | input | 1 | Supply is clear above battery level (battery mode) |
| sys_level | input | 1 | Logic level of the supply pin (single-supply mode) |
| rst_hold_cycles | input | 8 | Reset hold length after wake |
| pd_cmd | output | 1 | Power-down command bit, self-clearing |
| pse | output | 1 | Power-supply enable, high when running |
| clk_out_en | output | 1 | Clock output enable |
| cpu_rst_n | output | 1 | Processor reset, active low |
| ser_dis | output | 1 | Serial interface disable |

## Verification
The assertions assume that every input is already synchronous to clk. They also assume that batt_mode and rst_hold_cycles do not change between a power-down command and the release of reset, so the wake rule and the hold length stay fixed for each cycle. The stimulus changes inputs only on falling edges and reprograms mode and hold length only while the block is running. Supply fall and recovery are always driven on separate edges, matching the registered arm flag the block relies on.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int IRQ_N = 3;
  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_DOWN = 2'd1,
    PS_HOLD = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pwr_cmd_reg.sv
module pwr_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic in_run,
  input  logic wake_take,
  output logic pd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pd_q <= 1'b0;
    else if (wake_take)        pd_q <= 1'b0;
    else if (set_req && in_run) pd_q <= 1'b1;
  end

  // R9: a set request outside running never raises the bit
  assert_set_only_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(in_run));
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int IRQ_N = pwr_seq_pkg::IRQ_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_down,
  input  logic [IRQ_N-1:0] irq,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic             batt_mode,
  input  logic             sys_at_batt,
  input  logic             sys_above_batt,
  input  logic             sys_level,
  output logic             wake
);
  logic [IRQ_N-1:0] masked;
  logic             irq_wake;
  logic             fall_seen;
  logic             recover_seen;
  logic             armed_q;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_mask
    assign masked[g] = irq[g] & irq_en[g];
  end

  assign irq_wake     = |masked;
  assign fall_seen    = batt_mode ? sys_at_batt    : ~sys_level;
  assign recover_seen = batt_mode ? sys_above_batt :  sys_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (!in_down) armed_q <= 1'b0;
    else if (fall_seen) armed_q <= 1'b1;
  end

  assign wake = in_down && (irq_wake || (armed_q && recover_seen));

  // R7: a supply-driven wake needs the block to have been down on the previous edge
  assert_supply_wake_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !irq_wake) |-> $past(in_down));
endmodule

// File: rtl/pwr_hold_timer.sv
module pwr_hold_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             in_hold,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= len;
    else if (in_hold && !done) cnt <= cnt - ONE;
  end

  assign done = (cnt <= ONE);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_q,
  input  logic wake,
  input  logic hold_done,
  output logic in_run,
  output logic in_down,
  output logic in_hold,
  output logic wake_take,
  output logic pse,
  output logic clk_out_en,
  output logic cpu_rst_n,
  output logic ser_dis
);
  pwr_state_e state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      PS_RUN:  if (pd_q)      nxt = PS_DOWN;
      PS_DOWN: if (wake)      nxt = PS_HOLD;
      PS_HOLD: if (hold_done) nxt = PS_RUN;
      default:                nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_RUN;
    else        state <= nxt;
  end

  assign in_run    = (state == PS_RUN);
  assign in_down   = (state == PS_DOWN);
  assign in_hold   = (state == PS_HOLD);
  assign wake_take = in_down && wake;

  assign pse        = !in_down;
  assign clk_out_en = !in_down;
  assign cpu_rst_n  = in_run;
  assign ser_dis    = !in_run;

  // R3: leaving power-down requires a sampled wake
  assert_down_exit_on_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_down) && !in_down) |-> $past(wake));
  // R8: release happens only after the hold timer reports done
  assert_release_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_hold) && in_run) |-> $past(hold_done));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_cmd_set,
  input  logic [IRQ_N-1:0] irq,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic             batt_mode,
  input  logic             sys_at_batt,
  input  logic             sys_above_batt,
  input  logic             sys_level,
  input  logic [CNT_W-1:0] rst_hold_cycles,
  output logic             pd_cmd,
  output logic             pse,
  output logic             clk_out_en,
  output logic             cpu_rst_n,
  output logic             ser_dis
);
  logic in_run, in_down, in_hold, wake_take, wake, hold_done;

  pwr_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .set_req(pd_cmd_set), .in_run(in_run),
    .wake_take(wake_take), .pd_q(pd_cmd)
  );

  pwr_wake_detect #(.IRQ_N(IRQ_N)) u_wake (
    .clk(clk), .rst_n(rst_n), .in_down(in_down), .irq(irq), .irq_en(irq_en),
    .batt_mode(batt_mode), .sys_at_batt(sys_at_batt),
    .sys_above_batt(sys_above_batt), .sys_level(sys_level), .wake(wake)
  );

  pwr_hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(wake_take), .len(rst_hold_cycles),
    .in_hold(in_hold), .done(hold_done)
  );

  pwr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_q(pd_cmd), .wake(wake), .hold_done(hold_done),
    .in_run(in_run), .in_down(in_down), .in_hold(in_hold), .wake_take(wake_take),
    .pse(pse), .clk_out_en(clk_out_en), .cpu_rst_n(cpu_rst_n), .ser_dis(ser_dis)
  );

  // R2: the supply enable falls together with clock enable and processor reset
  assert_group_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pse) |-> (!clk_out_en && !cpu_rst_n && ser_dis));
  // R8: supply was already restored before the reset releases
  assert_pse_before_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $past(pse));
  // R8: serial disable releases with the reset
  assert_ser_with_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $fell(ser_dis));
  // R9: the command bit is clear once supply is back
  assert_cmd_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pse) |-> !pd_cmd);
endmodule

// File: tb/pwr_seq_top_test.sv
module pwr_seq_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_cmd_set = 1'b0;
  logic [2:0] irq = '0;
  logic [2:0] irq_en = '0;
  logic       batt_mode = 1'b0;
  logic       sys_at_batt = 1'b0;
  logic       sys_above_batt = 1'b1;
  logic       sys_level = 1'b1;
  logic [7:0] rst_hold_cycles = 8'd2;
  logic       pd_cmd, pse, clk_out_en, cpu_rst_n, ser_dis;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  pwr_seq_top uut (
    .clk(clk), .rst_n(rst_n), .pd_cmd_set(pd_cmd_set), .irq(irq), .irq_en(irq_en),
    .batt_mode(batt_mode), .sys_at_batt(sys_at_batt), .sys_above_batt(sys_above_batt),
    .sys_level(sys_level), .rst_hold_cycles(rst_hold_cycles), .pd_cmd(pd_cmd),
    .pse(pse), .clk_out_en(clk_out_en), .cpu_rst_n(cpu_rst_n), .ser_dis(ser_dis)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {28'd0, pse, clk_out_en, cpu_rst_n, ser_dis};
  endfunction

  localparam int RUNV  = 4'b1110;
  localparam int DOWNV = 4'b0001;
  localparam int HOLDV = 4'b1101;

  task automatic enter_down();
    @(negedge clk); pd_cmd_set = 1'b1;
    @(negedge clk); pd_cmd_set = 1'b0;
    chk("R2 pd_cmd set", int'(pd_cmd), 1);
    chk("R2 still running", outs(), RUNV);
    @(negedge clk);
    chk("R2 outputs down", outs(), DOWNV);
  endtask

  task automatic stay_down(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, outs(), DOWNV);
    end
  endtask

  // called at the negedge on which the wake stimulus was applied
  task automatic expect_wake(input string req, input int n);
    int held;
    int expn;
    expn = (n < 1) ? 1 : n;
    @(negedge clk);
    irq = '0; sys_at_batt = 1'b0; sys_above_batt = 1'b1; sys_level = 1'b1;
    chk({req, " R8 hold outputs"}, outs(), HOLDV);
    chk({req, " R9 pd_cmd cleared"}, int'(pd_cmd), 0);
    held = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cpu_rst_n) break;
      held++;
    end
    chk({req, " R8 hold length"}, held, expn);
    chk({req, " R8 released"}, outs(), RUNV);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", outs(), RUNV);
    chk("R1 reset pd_cmd", int'(pd_cmd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", outs(), RUNV);

    // R4: interrupts while running are ignored
    irq_en = 3'b111; irq = 3'b111;
    repeat (3) @(negedge clk);
    chk("R4 irq while running", outs(), RUNV);
    irq = '0;

    // R4 sweep over every source and every enable mask; hold length from mask
    for (int src = 0; src < 3; src++) begin
      for (int m = 0; m < 8; m++) begin
        irq_en = 3'(m); rst_hold_cycles = 8'(m);
        enter_down();
        @(negedge clk); irq[src] = 1'b1;
        if (m[src]) begin
          expect_wake("R4 enabled irq", m);
        end else begin
          stay_down("R4 disabled irq", 2);
          irq_en = 3'b111;
          expect_wake("R4 late enable", m);
        end
      end
    end
    irq_en = '0;

    // R3: no event keeps it down
    rst_hold_cycles = 8'd3;
    enter_down();
    stay_down("R3 idle down", 5);
    // R9: set pulse while down ignored
    @(negedge clk); pd_cmd_set = 1'b1;
    @(negedge clk); pd_cmd_set = 1'b0;
    chk("R9 set while down", outs(), DOWNV);
    irq_en = 3'b001; irq = 3'b001;
    expect_wake("R9 wake", 3);
    irq_en = '0;

    // R9: set pulse during reset hold ignored
    rst_hold_cycles = 8'd4;
    enter_down();
    @(negedge clk); irq_en = 3'b010; irq = 3'b010;
    @(negedge clk); irq = '0; pd_cmd_set = 1'b1;
    @(negedge clk); pd_cmd_set = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 set during hold", int'(pd_cmd), 0);
    chk("R9 stays running", outs(), RUNV);
    irq_en = '0;

    // R5: battery mode fall then recovery, for several hold lengths
    batt_mode = 1'b1;
    for (int n = 0; n < 4; n++) begin
      rst_hold_cycles = 8'(n);
      enter_down();
      stay_down("R7 recovery without fall", 2);
      @(negedge clk); sys_at_batt = 1'b1; sys_above_batt = 1'b0;
      stay_down("R5 at battery", n + 1);
      sys_at_batt = 1'b0; sys_above_batt = 1'b1;
      expect_wake("R5 battery recovery", n);
    end
    // R7: single-supply pin ignored in battery mode
    enter_down();
    @(negedge clk); sys_level = 1'b0;
    @(negedge clk); sys_level = 1'b1;
    stay_down("R7 level ignored in battery mode", 3);
    @(negedge clk); sys_at_batt = 1'b1; sys_above_batt = 1'b0;
    @(negedge clk); sys_at_batt = 1'b0; sys_above_batt = 1'b1;
    expect_wake("R5 battery second", 3);

    // R6: single-supply mode low then high
    batt_mode = 1'b0;
    for (int n = 1; n < 4; n++) begin
      rst_hold_cycles = 8'(n);
      enter_down();
      @(negedge clk); sys_level = 1'b0;
      stay_down("R6 supply low", n);
      sys_level = 1'b1;
      expect_wake("R6 supply back", n);
    end
    // R7: battery inputs ignored in single mode
    rst_hold_cycles = 8'd1;
    enter_down();
    @(negedge clk); sys_at_batt = 1'b1; sys_above_batt = 1'b0;
    @(negedge clk); sys_at_batt = 1'b0; sys_above_batt = 1'b1;
    stay_down("R7 battery ignored in single mode", 3);
    @(negedge clk); sys_level = 1'b0;
    @(negedge clk); sys_level = 1'b1;
    expect_wake("R6 after ignore", 1);
    // R7: fall while running does not arm
    @(negedge clk); sys_level = 1'b0;
    @(negedge clk); sys_level = 1'b1;
    enter_down();
    stay_down("R7 fall before power-down", 4);
    irq_en = 3'b100; irq = 3'b100;
    expect_wake("R4 power-sense wake", 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule